// File: doc/BRIEF.md
# Branch Trace Buffer

This block keeps a short history of program-flow discontinuities for debug. Each cycle the core may raise a one-cycle strobe carrying the source address and the target address of a taken jump or branch. While the buffer is powered and recording, every such strobe stores one entry. Software reads the history through a small register port with three registers: control, status and data.

The data register returns one 32-bit word per read, and the most recent entry comes out first. Each entry takes two reads. The first read returns the target address and the second returns the source address. Only the second read removes the entry. The buffer holds a fixed number of entries. When a capture arrives while the buffer is full, the oldest entry is lost and a sticky overflow flag is set.

The register port is combinational on the read side. `reg_rdata` reflects the addressed register in the same cycle that `reg_rd` is high. Any pop takes effect at the clock edge that ends that cycle.

Top module: `branch_trace_buffer`

## Requirements
- R1: After reset, control, status and data all read 0.
- R2: Control register (address 0) fields:
  - bit 0 turns the buffer on.
  - bit 1 turns recording on.
  - bit 2 is the overflow flag.
  - bit 3 is a loop-compression mode bit that always reads 0, and writes to it are ignored.
  - Bits 0 and 1 read back as written.
  - Writing 1 to bit 2 never sets it.
- R3: A strobe on `br_valid` while bits 0 and 1 are both 1 stores one entry, and status (address 1, count in its low bits) rises by one at the following edge.
- R4: A strobe while recording is off stores nothing and leaves status unchanged. Writing 1 to control (powered, not recording) keeps the stored entries.
- R5: Data reads (address 2) return entries newest first.
- R6: Within an entry, the first data read returns the target address and the second returns the source address. Status is unchanged after the first read and drops by one after the second.
- R7: A data read while status is 0 returns 0 and changes nothing, including which half of an entry the next read returns.
- R8: With 16 entries held, a new capture discards the oldest entry, keeps status at 16 and sets control bit 2.
- R9: The overflow flag stays set until software writes control with bit 2 equal to 0.
- R10: Writing control with bit 0 equal to 0 empties the buffer. It also makes the next data read return a target address.
- R11: A strobe in the same cycle as a data read is ignored.
- R12: A capture made between the two reads of an entry makes the next data read return the new entry's target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | One-cycle strobe for a taken discontinuity |
| br_src | input | 32 | Address of the jump or branch |
| br_dst | input | 32 | Address it goes to |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of `reg_rd` |

## Verification
A wrong stack pointer shows up on the very next data read as an address out of order. A stuck read-phase toggle shows up within two reads as a repeated target or a missing source. A count that moves on the wrong read shows in status after the first read of a pair. A lost or spurious capture shows in status one cycle after the strobe, and an overflow mistake shows in the control readback right after the seventeenth capture.

// File: rtl/btb_pkg.sv
package btb_pkg;

    localparam int BTB_AW = 32;

    // Control bit positions
    localparam int CTL_ON   = 0;
    localparam int CTL_REC  = 1;
    localparam int CTL_OVF  = 2;
    localparam int CTL_LOOP = 3;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_STAT = 2'd1,
        SEL_DATA = 2'd2,
        SEL_NONE = 2'd3
    } btb_sel_e;

    typedef struct packed {
        logic [BTB_AW-1:0] src;
        logic [BTB_AW-1:0] dst;
    } btb_pair_t;

    function automatic logic [31:0] ctrl_word(input logic on, input logic rec, input logic ovf);
        logic [31:0] w;
        w = '0;
        w[CTL_ON]  = on;
        w[CTL_REC] = rec;
        w[CTL_OVF] = ovf;
        return w;
    endfunction

endpackage

// File: rtl/btb_ctrl.sv
module btb_ctrl
    import btb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_ctrl,
    input  logic [31:0] wdata,
    input  logic        ovf_set,
    output logic        on_q,
    output logic        rec_q,
    output logic        ovf_q,
    output logic        flush,
    output logic [31:0] ctrl_rd
);

    always_ff @(posedge clk) begin
        if (rst) begin
            on_q  <= 1'b0;
            rec_q <= 1'b0;
            ovf_q <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                on_q  <= wdata[CTL_ON];
                rec_q <= wdata[CTL_REC];
            end
            // software may only clear the flag; a capture overflow sets it
            ovf_q <= ((wr_ctrl ? wdata[CTL_OVF] : 1'b1) & ovf_q) | ovf_set;
        end
    end

    assign flush   = wr_ctrl & ~wdata[CTL_ON];
    assign ctrl_rd = ctrl_word(on_q, rec_q, ovf_q);

endmodule

// File: rtl/btb_lifo.sv
module btb_lifo
    import btb_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  btb_pair_t     push_pair,
    input  logic          pop_rd,
    output logic [CW-1:0] count,
    output logic          phase,
    output logic          full,
    output btb_pair_t     head
);

    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    btb_pair_t     mem [DEPTH];
    logic [PW-1:0] top_q;
    logic [PW-1:0] top_up;
    logic [PW-1:0] top_dn;
    logic          empty;

    assign empty  = (count == '0);
    assign full   = (count == CW'(DEPTH));
    assign top_up = (top_q == LAST) ? '0 : top_q + PW'(1);
    assign top_dn = (top_q == '0) ? LAST : top_q - PW'(1);
    assign head   = mem[top_q];

    always_ff @(posedge clk) begin
        if (push && !flush) begin
            mem[top_up] <= push_pair;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            top_q <= '0;
            count <= '0;
            phase <= 1'b0;
        end else if (push) begin
            top_q <= top_up;
            phase <= 1'b0;
            if (!full) begin
                count <= count + CW'(1);
            end
        end else if (pop_rd && !empty) begin
            if (phase) begin
                phase <= 1'b0;
                top_q <= top_dn;
                count <= count - CW'(1);
            end else begin
                phase <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/btb_rdmux.sv
module btb_rdmux
    import btb_pkg::*;
#(
    parameter int CW = 5
) (
    input  btb_sel_e      sel,
    input  logic [31:0]   ctrl_rd,
    input  logic [CW-1:0] count,
    input  logic          phase,
    input  btb_pair_t     head,
    output logic [31:0]   rdata
);

    logic [31:0] data_word;

    always_comb begin
        if (count == '0) begin
            data_word = '0;
        end else if (phase) begin
            data_word = 32'(head.src);
        end else begin
            data_word = 32'(head.dst);
        end
    end

    always_comb begin
        unique case (sel)
            SEL_CTRL: rdata = ctrl_rd;
            SEL_STAT: rdata = 32'(count);
            SEL_DATA: rdata = data_word;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/branch_trace_buffer.sv
module branch_trace_buffer
    import btb_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        br_valid,
    input  logic [31:0] br_src,
    input  logic [31:0] br_dst,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata
);

    btb_sel_e      sel;
    logic          wr_ctrl;
    logic          data_rd;
    logic          on_q;
    logic          rec_q;
    logic          ovf_q;
    logic          flush;
    logic [31:0]   ctrl_rd;
    logic          capture;
    logic          full;
    logic          rd_phase;
    logic [CW-1:0] lvl;
    btb_pair_t     new_pair;
    btb_pair_t     head;

    assign sel      = btb_sel_e'(reg_addr);
    assign wr_ctrl  = reg_wr && (sel == SEL_CTRL);
    assign data_rd  = reg_rd && (sel == SEL_DATA);
    assign capture  = br_valid && on_q && rec_q && !data_rd;
    assign new_pair = '{src: br_src, dst: br_dst};

    btb_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_ctrl (wr_ctrl),
        .wdata   (reg_wdata),
        .ovf_set (capture && full),
        .on_q    (on_q),
        .rec_q   (rec_q),
        .ovf_q   (ovf_q),
        .flush   (flush),
        .ctrl_rd (ctrl_rd)
    );

    btb_lifo #(.DEPTH(DEPTH)) u_lifo (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .push      (capture),
        .push_pair (new_pair),
        .pop_rd    (data_rd),
        .count     (lvl),
        .phase     (rd_phase),
        .full      (full),
        .head      (head)
    );

    btb_rdmux #(.CW(CW)) u_rdmux (
        .sel     (sel),
        .ctrl_rd (ctrl_rd),
        .count   (lvl),
        .phase   (rd_phase),
        .head    (head),
        .rdata   (reg_rdata)
    );

endmodule

// File: rtl/btb_chk.sv
module btb_chk #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          br_valid,
    input logic          reg_wr,
    input logic          reg_rd,
    input logic [1:0]    reg_addr,
    input logic [31:0]   reg_wdata,
    input logic [31:0]   reg_rdata,
    input logic [CW-1:0] count,
    input logic          phase,
    input logic          rec,
    input logic          ovf
);

    logic data_rd;
    assign data_rd = reg_rd && (reg_addr == 2'd2);

    a_r3_capture_grows: assert property (@(posedge clk) disable iff (rst)
        (br_valid && rec && !data_rd && !reg_wr && count != CW'(DEPTH))
            |=> count == $past(count) + CW'(1));

    a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!rec && !reg_wr && !data_rd) |=> count == $past(count));

    a_r6_first_read_keeps: assert property (@(posedge clk) disable iff (rst)
        (data_rd && count != '0 && !phase) |=> (count == $past(count)) && phase);

    a_r6_second_read_drops: assert property (@(posedge clk) disable iff (rst)
        (data_rd && count != '0 && phase) |=> (count == $past(count) - CW'(1)) && !phase);

    a_r7_empty_zero: assert property (@(posedge clk) disable iff (rst)
        (data_rd && count == '0) |-> reg_rdata == 32'd0);

    a_r7_empty_no_change: assert property (@(posedge clk) disable iff (rst)
        (data_rd && count == '0) |=> count == '0 && $stable(phase));

    a_r8_count_cap: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    a_r8_overflow_sets: assert property (@(posedge clk) disable iff (rst)
        (br_valid && rec && !data_rd && !reg_wr && count == CW'(DEPTH)) |=> ovf);

    a_r10_flush_empties: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd0 && !reg_wdata[0]) |=> count == '0 && !phase);

    a_r11_read_blocks_capture: assert property (@(posedge clk) disable iff (rst)
        (data_rd && br_valid && count == '0) |=> count == '0);

endmodule

bind branch_trace_buffer btb_chk #(.DEPTH(DEPTH)) u_btb_chk (
    .clk       (clk),
    .rst       (rst),
    .br_valid  (br_valid),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .count     (lvl),
    .phase     (rd_phase),
    .rec       (on_q && rec_q),
    .ovf       (ovf_q)
);

// File: tb/test_branch_trace_buffer.sv
module test_branch_trace_buffer;

    localparam int CLK_P = 10;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        br_valid = 1'b0;
    logic [31:0] br_src = '0;
    logic [31:0] br_dst = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #(CLK_P/2) clk = ~clk;

    branch_trace_buffer #(.DEPTH(DEPTH)) i_branch_trace_buffer (
        .clk, .rst, .br_valid, .br_src, .br_dst,
        .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata
    );

    // monitor: compares each read against the queued expectation
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_P/4);
            if (reg_rd && exp_q.size() > 0) begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_checks++;
                if (reg_rdata !== e) begin
                    n_fail++;
                    $display("FAIL %s: got 0x%08h expected 0x%08h", t, reg_rdata, e);
                end
            end
        end
    end

    task automatic rd_exp(input logic [1:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        reg_rd = 1'b1;
        reg_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(posedge clk);
        #1;
        reg_rd = 1'b0;
    endtask

    task automatic rd_with_branch(input logic [31:0] e, input string t);
        @(negedge clk);
        reg_rd = 1'b1;
        reg_addr = 2'd2;
        br_valid = 1'b1;
        br_src = 32'hDEAD_0001;
        br_dst = 32'hDEAD_0002;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(posedge clk);
        #1;
        reg_rd = 1'b0;
        br_valid = 1'b0;
    endtask

    task automatic wr_ctl(input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_addr = 2'd0;
        reg_wdata = v;
        @(posedge clk);
        #1;
        reg_wr = 1'b0;
    endtask

    task automatic branch(input logic [31:0] s, input logic [31:0] d);
        @(negedge clk);
        br_valid = 1'b1;
        br_src = s;
        br_dst = d;
        @(posedge clk);
        #1;
        br_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd_exp(2'd0, 32'd0, "R1 control");
        rd_exp(2'd1, 32'd0, "R1 status");
        rd_exp(2'd2, 32'd0, "R1 data");

        // R2 control fields, bit 3 and bit 2 not settable
        wr_ctl(32'hF);
        rd_exp(2'd0, 32'h3, "R2 control readback");

        // R3 three captures
        branch(32'h224, 32'h250);
        branch(32'h25a, 32'h234);
        branch(32'h23c, 32'h26c);
        rd_exp(2'd1, 32'd3, "R3 status after three");

        // R4 stop keeps contents, strobes ignored
        wr_ctl(32'h1);
        branch(32'h999, 32'h888);
        rd_exp(2'd1, 32'd3, "R4 status while stopped");
        rd_exp(2'd0, 32'h1, "R4 control stopped");

        // R5 / R6 newest first, target then source
        rd_exp(2'd2, 32'h26c, "R5 R6 newest target");
        rd_exp(2'd1, 32'd3,   "R6 status after first read");
        rd_exp(2'd2, 32'h23c, "R6 newest source");
        rd_exp(2'd1, 32'd2,   "R6 status after second read");
        rd_exp(2'd2, 32'h234, "R5 middle target");
        rd_exp(2'd2, 32'h25a, "R5 middle source");
        rd_exp(2'd1, 32'd1,   "R6 status one left");
        rd_exp(2'd2, 32'h250, "R5 oldest target");
        rd_exp(2'd2, 32'h224, "R5 oldest source");
        rd_exp(2'd1, 32'd0,   "R6 status empty");

        // R7 empty read
        rd_exp(2'd2, 32'd0, "R7 empty read");
        rd_exp(2'd1, 32'd0, "R7 status after empty read");
        wr_ctl(32'h3);
        branch(32'h4000, 32'h4100);
        rd_exp(2'd2, 32'h4100, "R7 phase kept after empty read");
        rd_exp(2'd2, 32'h4000, "R7 source follows");

        // R11 strobe during data read ignored
        rd_with_branch(32'd0, "R11 read data while empty");
        rd_exp(2'd1, 32'd0, "R11 status no capture");

        // R12 capture between the two reads of a pair
        branch(32'hA0, 32'hA1);
        rd_exp(2'd2, 32'hA1, "R12 first target");
        branch(32'hB0, 32'hB1);
        rd_exp(2'd2, 32'hB1, "R12 new target first");
        rd_exp(2'd2, 32'hB0, "R12 new source");
        rd_exp(2'd2, 32'hA1, "R12 old pair restarts at target");
        rd_exp(2'd2, 32'hA0, "R12 old source");

        // R8 overflow
        for (int i = 0; i < DEPTH + 2; i++) begin
            branch(32'h1000 + i, 32'h2000 + i);
        end
        rd_exp(2'd1, 32'd16, "R8 status capped");
        rd_exp(2'd0, 32'h7,  "R8 overflow flag");
        for (int i = DEPTH + 1; i >= 2; i--) begin
            rd_exp(2'd2, 32'h2000 + i, "R8 target order");
            rd_exp(2'd2, 32'h1000 + i, "R8 source order");
        end
        rd_exp(2'd1, 32'd0, "R8 oldest two discarded");

        // R9 sticky overflow
        wr_ctl(32'h7);
        rd_exp(2'd0, 32'h7, "R9 write one keeps flag");
        wr_ctl(32'h3);
        rd_exp(2'd0, 32'h3, "R9 write zero clears flag");

        // R10 power down flushes
        branch(32'h50, 32'h51);
        branch(32'h60, 32'h61);
        rd_exp(2'd2, 32'h61, "R10 half read before flush");
        wr_ctl(32'h0);
        rd_exp(2'd0, 32'h0, "R10 control off");
        rd_exp(2'd1, 32'd0, "R10 status flushed");
        wr_ctl(32'h3);
        rd_exp(2'd2, 32'd0, "R10 data empty after flush");
        branch(32'h70, 32'h71);
        rd_exp(2'd2, 32'h71, "R10 phase reset to target");

        @(negedge clk);
        #(CLK_P/2);
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R1 scoreboard: got %0d pending expected 0", exp_q.size());
        end
        finish_run();
    end

endmodule